// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sends one clause-22 management frame to a PHY over the two-wire management bus each time it accepts a 32-bit frame word. The management clock (MDC) is made from the system clock by a programmable divider. An optional preamble of 32 ones precedes the frame. The start, opcode, PHY address and register address fields then go out MSB first, followed by the turnaround. A write drives the two turnaround bits and all 16 data bits. A read releases the data line at the turnaround and captures 16 data bits from the PHY into the low half of the held frame word. When the frame ends, an event flag is set. The flag is cleared by a one-cycle clear pulse, and a mask input gates it onto the interrupt line.

The frame word enters on a valid/ready port. `frame_ready` is high only when no frame is in progress and the divider is non-zero. A word is taken on a clock edge where `frame_valid` and `frame_ready` are both high. A word offered while `frame_ready` is low is not taken and is not stored, so the source may withdraw it. The configuration inputs (divider, preamble suppress, hold time) are plain levels and must stay stable while `busy` is high. The word layout is: data in bits 15:0, turnaround in 17:16, register address in 22:18, PHY address in 27:23, opcode in 29:28 and start delimiter in 31:30. Opcode values 0 and 1 are writes and values 2 and 3 are reads, so bit 29 selects the direction.

Top module: `mgmt_frame_master`

## Requirements
- R1: A word is accepted only when frame_valid and frame_ready are both high at a clock edge. The line then carries the word's bits 31 down to 0, one per MDC rising edge, after the preamble if one is enabled. Each bit is set up before its rising edge.
- R2: While a frame runs, MDC is low for the first 2×div_cfg clocks and then toggles every 2×div_cfg system clocks. MDC is low whenever busy is low.
- R3: When div_cfg is 0, frame_ready is low, no word is taken and MDC stays low.
- R4: With no_pre low, a frame has 64 MDC rising edges, the first 32 carrying a one with output enabled. With no_pre high, a frame has 32 rising edges and no preamble.
- R5: For opcodes 0 and 1 (bit 29 low), mdio_oe is high for all frame bits. For opcodes 2 and 3 (bit 29 high), mdio_oe is high for frame bits 31 to 18 and low from the turnaround bit 17 to the end.
- R6: For a read, mdio_i is sampled on the rising edges of frame bits 15 down to 0. The first sample lands in frame_q bit 15 and the last in bit 0. frame_q bits 31:16 keep the accepted word.
- R7: mdio_o changes exactly min(hold_cfg+1, 2×div_cfg−1) system clocks after the MDC falling edge that ends the previous bit, and never on an MDC edge.
- R8: On the clock edge where the frame's last MDC falling edge occurs, busy drops and evt_flag is set. irq equals evt_flag AND evt_mask.
- R9: A one-cycle evt_clr pulse clears evt_flag. A completion in the same cycle wins over the clear.
- R10: A word offered while a frame runs is ignored: frame_ready is low, and the running frame and frame_q are unaffected.
- R11: After reset, MDC, mdio_oe, busy, evt_flag, irq and frame_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Frame word offered |
| frame_ready | output | 1 | Idle and divider non-zero; word can be taken |
| frame_word | input | 32 | Frame word to send |
| frame_q | output | 32 | Held frame word; low half holds read data after a read |
| div_cfg | input | DIV_W | MDC divider; half period is 2×div_cfg clocks, 0 disables |
| no_pre | input | 1 | Suppress the 32-bit preamble |
| hold_cfg | input | HOLD_W | Output hold after the MDC fall, in clocks minus one |
| busy | output | 1 | Frame in progress |
| evt_flag | output | 1 | Frame-complete event flag |
| evt_clr | input | 1 | Clear pulse for evt_flag |
| evt_mask | input | 1 | Enables evt_flag onto irq |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
The bench builds the block with its default widths (a 6-bit divider and a 3-bit hold field). It runs small divider values, from 1 to 6, so that every frame stays short. At divider values 1, 2 and 4 the half period is short enough that the hold time is clamped to one clock before the next rising edge. At divider 5 the full 8-clock hold fits, so both the clamped and the unclamped delay are measured. The bench mixes all four opcodes, both preamble settings and both mask settings. An emulated PHY returns chosen read data, so capture order and bus release are checked against the word layout.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  localparam int FRAME_W  = 32;   // bits in one management frame
  localparam int PRE_LEN  = 32;   // ones sent ahead of the frame
  localparam int DATA_W   = 16;   // data field width
  localparam int TA_POS   = 14;   // frame bit index (from MSB) of the turnaround
  localparam int DATA_POS = 16;   // frame bit index (from MSB) of the first data bit
  localparam int OP_MSB   = 29;   // opcode bit that selects a read
  localparam int POS_W    = $clog2(PRE_LEN + FRAME_W);
  localparam int IDX_W    = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    OP_WR_ALT = 2'd0,
    OP_WR     = 2'd1,
    OP_RD     = 2'd2,
    OP_RD_ALT = 2'd3
  } mfm_op_e;
endpackage

// File: rtl/mfm_clkgen.sv
module mfm_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W:0]   half_len,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             term;

  assign half_len = {div, 1'b0};
  assign term     = (cnt == half_len - CNT_W'(1));
  assign rise_evt = en & term & ~mdc;
  assign fall_evt = en & term & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mfm_hold.sv
module mfm_hold #(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic [DIV_W:0]    half_len,
  output logic              step
);
  localparam int CNT_W = DIV_W + 1;
  localparam int D_W   = (HOLD_W + 1 > CNT_W) ? HOLD_W + 1 : CNT_W;

  logic [D_W-1:0] want, cap, eff, cnt;

  // requested delay, clamped so the new bit settles before the next rising edge
  assign want = D_W'(hold_cfg) + D_W'(1);
  assign cap  = D_W'(half_len) - D_W'(1);
  assign eff  = (want < cap) ? want : cap;
  assign step = (cnt == D_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= eff;
    else if (cnt != '0)     cnt <= cnt - D_W'(1);
  end
endmodule

// File: rtl/mfm_shifter.sv
module mfm_shifter
  import mfm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [FRAME_W-1:0] word,
  input  logic               no_pre,
  input  logic               step,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_i,
  output logic               busy,
  output logic               last,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [FRAME_W-1:0] frame_q
);
  logic [POS_W-1:0] pos, np, pre_len, last_pos;
  logic             pre_l, rd;

  function automatic logic bit_at(input logic [POS_W-1:0] p,
                                  input logic [POS_W-1:0] pre,
                                  input logic [FRAME_W-1:0] w);
    logic [IDX_W-1:0] idx;
    idx = IDX_W'(p - pre);
    if (p < pre) return 1'b1;
    return w[IDX_W'(FRAME_W - 1) - idx];
  endfunction

  assign pre_len  = pre_l ? '0 : POS_W'(PRE_LEN);
  assign last_pos = pre_len + POS_W'(FRAME_W - 1);
  assign np       = pos + POS_W'(1);
  assign rd       = frame_q[OP_MSB];
  assign last     = busy && (pos == last_pos);
  assign done     = fall_evt && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pos     <= '0;
      pre_l   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      frame_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      pos     <= '0;
      pre_l   <= no_pre;
      frame_q <= word;
      mdio_o  <= no_pre ? word[FRAME_W-1] : 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (step) begin
        pos    <= np;
        mdio_o <= bit_at(np, pre_len, frame_q);
        if (rd && (np >= pre_len + POS_W'(TA_POS))) mdio_oe <= 1'b0;
      end
      if (rise_evt && rd && (pos >= pre_len + POS_W'(DATA_POS)))
        frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
      if (done) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mfm_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [FRAME_W-1:0] frame_q,
  input  logic [DIV_W-1:0]   div_cfg,
  input  logic               no_pre,
  input  logic [HOLD_W-1:0]  hold_cfg,
  output logic               busy,
  output logic               evt_flag,
  input  logic               evt_clr,
  input  logic               evt_mask,
  output logic               irq,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic [DIV_W:0] half_len;
  logic           rise_evt, fall_evt, step, last, done, accept;

  assign frame_ready = !busy && (div_cfg != '0);
  assign accept      = frame_valid && frame_ready;
  assign irq         = evt_flag && evt_mask;

  mfm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(busy), .div(div_cfg),
    .half_len(half_len), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mfm_hold #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(fall_evt && !last),
    .hold_cfg(hold_cfg), .half_len(half_len), .step(step)
  );

  mfm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(frame_word),
    .no_pre(no_pre), .step(step), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .last(last), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_q(frame_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_flag <= 1'b0;
    else if (done)    evt_flag <= 1'b1;
    else if (evt_clr) evt_flag <= 1'b0;
  end
endmodule

// File: rtl/mfm_checker.sv
module mfm_checker #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             frame_ready,
  input logic [31:0]      frame_q,
  input logic [DIV_W-1:0] div_cfg,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             evt_flag,
  input logic             evt_mask,
  input logic             irq
);
  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2

  AST_ZERO_DIV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cfg == '0 && !busy) |=> !busy); // R3

  AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frame_ready); // R10

  AST_BUSY_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_valid) |=> $stable(frame_q[31:16])); // R10

  AST_MDIO_QUIET_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) || $fell(mdc)) |-> $stable(mdio_o)); // R7

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_flag); // R8

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && evt_mask) |-> irq); // R8
endmodule

bind mgmt_frame_master mfm_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
  .frame_q(frame_q), .div_cfg(div_cfg), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .evt_flag(evt_flag), .evt_mask(evt_mask), .irq(irq)
);

// File: tb/tb_mgmt_frame_master.sv
`timescale 1ns/1ps
module tb_mgmt_frame_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic        frame_ready;
  logic [31:0] frame_word = '0;
  logic [31:0] frame_q;
  logic [5:0]  div_cfg = 6'd3;
  logic        no_pre = 1'b0;
  logic [2:0]  hold_cfg = 3'd0;
  logic        busy, evt_flag, irq, mdc, mdio_o, mdio_oe;
  logic        evt_clr = 1'b0;
  logic        evt_mask = 1'b0;
  logic        mdio_i = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  mgmt_frame_master dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_word(frame_word), .frame_q(frame_q), .div_cfg(div_cfg), .no_pre(no_pre),
    .hold_cfg(hold_cfg), .busy(busy), .evt_flag(evt_flag), .evt_clr(evt_clr),
    .evt_mask(evt_mask), .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- line monitor and PHY model (samples mid-cycle) -------------
  logic        mon_rst = 1'b1;
  int          pre = 32;
  logic [15:0] phy_word = '0;
  logic        prev_mdc, prev_o, tog_seen, fall_seen;
  int          since_tog, since_fall, hp_min, hp_max, hd_min, hd_max, nrise;
  logic        cap_o [64];
  logic        cap_oe [64];

  always @(negedge clk) begin
    if (mon_rst) begin
      tog_seen = 0; fall_seen = 0; since_tog = 0; since_fall = 0;
      hp_min = 9999; hp_max = 0; hd_min = 9999; hd_max = 0; nrise = 0;
    end else begin
      since_tog++;
      since_fall++;
      if (mdc !== prev_mdc) begin
        if (tog_seen) begin
          if (since_tog < hp_min) hp_min = since_tog;
          if (since_tog > hp_max) hp_max = since_tog;
        end
        tog_seen = 1; since_tog = 0;
        if (!mdc) begin
          fall_seen = 1; since_fall = 0;
        end else begin
          if (nrise < 64) begin
            cap_o[nrise] = mdio_o; cap_oe[nrise] = mdio_oe;
          end
          nrise++;
        end
      end
      if (mdio_o !== prev_o && fall_seen) begin
        if (since_fall < hd_min) hd_min = since_fall;
        if (since_fall > hd_max) hd_max = since_fall;
      end
    end
    if (nrise >= pre + 16 && nrise < pre + 32) mdio_i = phy_word[pre + 31 - nrise];
    else mdio_i = 1'b0;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic clear_mon();
    @(posedge clk); mon_rst = 1'b1;
    @(posedge clk); mon_rst = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk); frame_word = w; frame_valid = 1'b1;
    @(negedge clk); frame_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 40000) begin
      @(negedge clk); guard++;
    end
    if (busy) chk("R8 frame never completed", 32'd1, 32'd0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // count mismatches between captured line bits and the expected frame
  function automatic int bit_errs(input logic [31:0] w, input int p);
    int e = 0;
    for (int r = 0; r < p + 32 && r < 64; r++) begin
      int k = r - p;
      if (r < p) begin
        if (cap_o[r] !== 1'b1 || cap_oe[r] !== 1'b1) e++;
      end else if (w[29] && k >= 14) begin
        if (cap_oe[r] !== 1'b0) e++;
      end else begin
        if (cap_o[r] !== w[31 - k] || cap_oe[r] !== 1'b1) e++;
      end
    end
    return e;
  endfunction

  // {op, pa, ra, data, div, no_pre, hold, phy}
  localparam logic [53:0] VEC [6] = '{
    {2'd1, 5'd10, 5'd21, 16'hA5C3, 6'd3, 1'b0, 3'd0, 16'h0000},
    {2'd0, 5'd3,  5'd12, 16'h3C96, 6'd2, 1'b1, 3'd2, 16'h0000},
    {2'd2, 5'd17, 5'd5,  16'h1234, 6'd5, 1'b0, 3'd7, 16'hC35A},
    {2'd3, 5'd30, 5'd9,  16'hFFFF, 6'd1, 1'b1, 3'd5, 16'h9E01},
    {2'd1, 5'd21, 5'd10, 16'h5555, 6'd4, 1'b1, 3'd7, 16'h0000},
    {2'd2, 5'd6,  5'd27, 16'h0000, 6'd6, 1'b1, 3'd1, 16'h0F0F}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] w, wa, wb;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 mdc", {31'd0, mdc}, 32'd0);
    chk("R11 mdio_oe", {31'd0, mdio_oe}, 32'd0);
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 evt_flag/irq", {30'd0, evt_flag, irq}, 32'd0);
    chk("R11 frame_q", frame_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready when idle", {31'd0, frame_ready}, 32'd1);

    for (int i = 0; i < 6; i++) begin
      logic [53:0] v;
      int hp, eff;
      v = VEC[i];
      w        = {2'b01, v[53:52], v[51:47], v[46:42], 2'b10, v[41:26]};
      div_cfg  = v[25:20];
      no_pre   = v[19];
      hold_cfg = v[18:16];
      phy_word = v[15:0];
      evt_mask = i[0];
      pre      = no_pre ? 0 : 32;
      hp       = 2 * int'(div_cfg);
      eff      = (int'(hold_cfg) + 1 < hp - 1) ? int'(hold_cfg) + 1 : hp - 1;
      clear_mon();
      send(w);
      wait_idle();
      chk($sformatf("R4 rising edges v%0d", i), nrise, pre + 32);
      chk($sformatf("R1 R5 line bits v%0d", i), bit_errs(w, pre), 0);
      chk($sformatf("R2 half period min v%0d", i), hp_min, hp);
      chk($sformatf("R2 half period max v%0d", i), hp_max, hp);
      chk($sformatf("R7 hold min v%0d", i), hd_min, eff);
      chk($sformatf("R7 hold max v%0d", i), hd_max, eff);
      if (w[29]) chk($sformatf("R6 read capture v%0d", i), frame_q, {w[31:16], phy_word});
      else       chk($sformatf("R1 write word kept v%0d", i), frame_q, w);
      chk($sformatf("R5 released after frame v%0d", i), {31'd0, mdio_oe}, 32'd0);
      chk($sformatf("R8 flag v%0d", i), {31'd0, evt_flag}, 32'd1);
      chk($sformatf("R8 irq mask v%0d", i), {31'd0, irq}, {31'd0, evt_mask});
      @(negedge clk); evt_clr = 1'b1;
      @(negedge clk); evt_clr = 1'b0;
      chk($sformatf("R9 flag cleared v%0d", i), {31'd0, evt_flag}, 32'd0);
    end

    // R3: divider zero starts nothing
    wa = frame_q;
    div_cfg = 6'd0;
    @(negedge clk);
    chk("R3 ready low with div 0", {31'd0, frame_ready}, 32'd0);
    clear_mon();
    send(32'h6B5A_1234);
    repeat (40) @(negedge clk);
    chk("R3 no busy", {31'd0, busy}, 32'd0);
    chk("R3 no mdc edges", nrise, 0);
    chk("R3 frame_q unchanged", frame_q, wa);
    chk("R3 no event", {31'd0, evt_flag}, 32'd0);

    // R10: word offered mid-frame is ignored
    div_cfg = 6'd2; no_pre = 1'b1; hold_cfg = 3'd0; pre = 0;
    wa = {2'b01, 2'd1, 5'd9, 5'd18, 2'b10, 16'hC0DE};
    wb = {2'b01, 2'd2, 5'd1, 5'd2, 2'b10, 16'h0001};
    clear_mon();
    send(wa);
    repeat (10) @(negedge clk);
    chk("R10 not ready while busy", {31'd0, frame_ready}, 32'd0);
    send(wb);
    wait_idle();
    chk("R10 frame_q keeps first word", frame_q, wa);
    chk("R10 edge count of first frame", nrise, 32);
    chk("R10 line bits of first frame", bit_errs(wa, 0), 0);
    chk("R10 only one frame ran", {31'd0, busy}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule